// File: doc/BRIEF.md
# Inverted Bit-Timed Serial Byte Transmitter

This block sends one byte at a time on a single output line. The line levels are the inverse of a standard UART. A cell of one bit does not last a whole number of baud periods. Instead it lasts a fixed number of pulses on a tick-enable input, and that tick is meant to run at 0.5 µs. The start cell and the stop cell are each one tick shorter than a data cell. The resulting frame is a start cell, eight data cells sent LSB first, and a stop cell.

Bytes arrive over a valid/ready handshake. A `busy` flag covers the whole frame. The block does not restart a counter at each edge. It keeps one count of elapsed ticks from the moment the byte is accepted. Each cell boundary is a deadline, found by adding the next cell's length to the previous deadline. Rounding therefore never builds up across the frame.

Top module: `invtx_top`

## Requirements
- R1: After synchronous reset `line_o` is low, `busy_o` is low and `in_ready` is high.
- R2: The cycle after a byte is accepted (`in_valid && in_ready` at a clock edge), `line_o` is high. It stays high for exactly START_TICKS (34) tick pulses.
- R3: DATA_BITS (8) data cells follow the start cell, least significant bit first. Each lasts exactly DATA_TICKS (35) tick pulses.
- R4: A data bit of 1 drives `line_o` low. A data bit of 0 drives it high.
- R5: The stop cell drives `line_o` low for exactly STOP_TICKS (34) tick pulses. The whole frame is therefore 348 tick pulses long. While `busy_o` is low the line stays low.
- R6: `in_ready` is low while a frame is in flight. `in_valid` and `in_data` are ignored during that time and do not change the frame being sent.
- R7: `busy_o` rises the cycle after acceptance. It falls the cycle after the tick pulse that ends the stop cell. A new byte can then be accepted at the very next clock edge.
- R8: Every change of `line_o` inside a frame happens in the cycle after a tick pulse. Each cell boundary lies at the running sum of the cell lengths counted from acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle timing pulse, nominally every 0.5 µs |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte this cycle |
| line_o | output | 1 | Inverted serial output line |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong elapsed count or deadline shows up as a cell that is one or more ticks too long or too short. The sample-by-sample comparison at each tick catches this at the first misplaced boundary, within 35 ticks of the error. A wrong bit index or shift state sends a level that does not match the expected one within a single data cell. A wrong phase state shows up as a frame that is not 348 ticks long, or as `in_ready` rising early. The second of these lets a mid-frame byte corrupt the output before the next tick.

// File: rtl/invtx_pkg.sv
package invtx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;
endpackage

// File: rtl/invtx_deadline.sv
// Frame-relative tick counter with an accumulated deadline.
module invtx_deadline #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] first_len,
  input  logic [CNT_W-1:0] next_len,
  output logic             cell_done
);
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] deadline_q;
  logic [CNT_W-1:0] elapsed_inc;

  assign elapsed_inc = elapsed_q + 1'b1;
  assign cell_done   = run && tick && (elapsed_inc == deadline_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q  <= '0;
      deadline_q <= '0;
    end else if (load) begin
      elapsed_q  <= '0;
      deadline_q <= first_len;
    end else if (run && tick) begin
      elapsed_q <= elapsed_inc;
      if (cell_done) deadline_q <= deadline_q + next_len;
    end
  end
endmodule

// File: rtl/invtx_shifter.sv
// Holds the byte, exposes current and upcoming bit, tracks the bit index.
module invtx_shifter #(
  parameter int DATA_BITS = 8,
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 shift,
  input  logic [DATA_BITS-1:0] din,
  output logic                 cur_bit,
  output logic                 nxt_bit,
  output logic                 last_bit
);
  logic [DATA_BITS-1:0] data_q;
  logic [IDX_W-1:0]     idx_q;

  assign cur_bit  = data_q[0];
  assign last_bit = (idx_q == IDX_W'(DATA_BITS - 1));

  generate
    if (DATA_BITS > 1) begin : g_multi
      assign nxt_bit = data_q[1];
    end else begin : g_single
      assign nxt_bit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      data_q <= din;
      idx_q  <= '0;
    end else if (shift) begin
      data_q <= data_q >> 1;
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/invtx_top.sv
module invtx_top #(
  parameter int DATA_BITS   = 8,
  parameter int START_TICKS = 34,
  parameter int DATA_TICKS  = 35,
  parameter int STOP_TICKS  = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 line_o,
  output logic                 busy_o
);
  import invtx_pkg::*;

  localparam int FRAME_TICKS = START_TICKS + DATA_BITS * DATA_TICKS + STOP_TICKS;
  localparam int CNT_W       = $clog2(FRAME_TICKS + 1);

  phase_e           phase_q, phase_d;
  logic             line_q, line_d;
  logic             accept, cell_done, run;
  logic             cur_bit, nxt_bit, last_bit, shift;
  logic [CNT_W-1:0] next_len;

  assign in_ready = (phase_q == PH_IDLE);
  assign busy_o   = (phase_q != PH_IDLE);
  assign line_o   = line_q;
  assign accept   = in_valid && in_ready;
  assign run      = busy_o;
  assign shift    = cell_done && (phase_q == PH_DATA) && !last_bit;

  invtx_deadline #(.CNT_W(CNT_W)) u_deadline (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .run       (run),
    .tick      (tick_i),
    .first_len (CNT_W'(START_TICKS)),
    .next_len  (next_len),
    .cell_done (cell_done)
  );

  invtx_shifter #(.DATA_BITS(DATA_BITS)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .shift    (shift),
    .din      (in_data),
    .cur_bit  (cur_bit),
    .nxt_bit  (nxt_bit),
    .last_bit (last_bit)
  );

  always_comb begin
    phase_d  = phase_q;
    line_d   = line_q;
    next_len = '0;
    case (phase_q)
      PH_IDLE: begin
        line_d = 1'b0;
        if (accept) begin
          phase_d = PH_START;
          line_d  = 1'b1;
        end
      end
      PH_START: begin
        next_len = CNT_W'(DATA_TICKS);
        if (cell_done) begin
          phase_d = PH_DATA;
          line_d  = ~cur_bit;
        end
      end
      PH_DATA: begin
        next_len = last_bit ? CNT_W'(STOP_TICKS) : CNT_W'(DATA_TICKS);
        if (cell_done) begin
          if (last_bit) begin
            phase_d = PH_STOP;
            line_d  = 1'b0;
          end else begin
            line_d = ~nxt_bit;
          end
        end
      end
      PH_STOP: begin
        if (cell_done) begin
          phase_d = PH_IDLE;
          line_d  = 1'b0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        line_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      line_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      line_q  <= line_d;
    end
  end
endmodule

// File: rtl/invtx_checker.sv
module invtx_checker (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic in_valid,
  input logic in_ready,
  input logic line_o,
  input logic busy_o
);
  AST_ACCEPT_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (busy_o && line_o)); // R2

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !line_o); // R5

  AST_NO_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !in_ready); // R6

  AST_EDGE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && (line_o != $past(line_o))) |-> $past(tick_i)); // R8

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(tick_i)); // R7
endmodule

bind invtx_top invtx_checker u_invtx_checker (
  .clk      (clk),
  .rst      (rst),
  .tick_i   (tick_i),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .line_o   (line_o),
  .busy_o   (busy_o)
);

// File: tb/tb_invtx_top.sv
`timescale 1ns/1ps
module tb_invtx_top;
  localparam int START_T = 34;
  localparam int DATA_T  = 35;
  localparam int STOP_T  = 34;
  localparam int FRAME_T = START_T + 8 * DATA_T + STOP_T;
  localparam int TDIV    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, line_o, busy_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic       samp[FRAME_T + 8];
  int         nsamp = 0;
  int         idle_cnt = 0;
  int         last_gap = -1;
  logic       prev_busy = 1'b0;
  bit         done = 1'b0;

  invtx_top dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .line_o(line_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  initial begin
    @(posedge clk);
    forever begin
      repeat (TDIV - 1) @(posedge clk);
      tick_i <= 1'b1;
      @(posedge clk);
      tick_i <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: samples the line at every tick of a frame, scores frame at end.
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o && !prev_busy) begin
        last_gap = idle_cnt;
        nsamp = 0;
      end
      if (!busy_o) idle_cnt++;
      else idle_cnt = 0;
      if (busy_o && tick_i && nsamp < FRAME_T + 8) begin
        samp[nsamp] = line_o;
        nsamp++;
      end
      if (!busy_o && prev_busy) begin
        logic [7:0] b;
        bit ok;
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected frame", 1, 0);
        end else begin
          b = exp_q.pop_front();
          check(nsamp == FRAME_T, "R5 frame length", nsamp, FRAME_T);
          ok = 1;
          for (int k = 0; k < START_T; k++) if (samp[k] !== 1'b1) ok = 0;
          check(ok, "R2 start cell high", ok, 1);
          for (int i = 0; i < 8; i++) begin
            ok = 1;
            for (int k = 0; k < DATA_T; k++)
              if (samp[START_T + i*DATA_T + k] !== ~b[i]) ok = 0;
            check(ok, $sformatf("R3 R4 data cell %0d of byte %0h", i, b), ok, 1);
          end
          ok = 1;
          for (int k = 0; k < STOP_T; k++)
            if (samp[START_T + 8*DATA_T + k] !== 1'b0) ok = 0;
          check(ok, "R5 stop cell low", ok, 1);
        end
      end
      prev_busy = busy_o;
    end
  end

  // Driver: offers a byte, pushes expectation at acceptance.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(line_o == 1'b0, "R1 line after reset", line_o, 0);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    send(8'hA5);
    check(busy_o == 1'b1, "R7 busy after accept", busy_o, 1);
    check(line_o == 1'b1, "R2 line high after accept", line_o, 1);
    // R6: offer a different byte mid-frame; it must be ignored
    repeat (200) @(negedge clk);
    check(in_ready == 1'b0, "R6 ready low mid-frame", in_ready, 0);
    in_valid = 1'b1;
    in_data  = 8'h00;
    repeat (300) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    check(line_o == 1'b0, "R5 idle line low", line_o, 0);

    send(8'h00);
    send(8'hFF);
    @(negedge clk);
    check(last_gap == 1, "R7 back-to-back accept gap", last_gap, 1);
    send(8'h01);
    send(8'h80);
    wait_idle();
    check(in_ready == 1'b1, "R7 ready after frame", in_ready, 1);
    check(line_o == 1'b0, "R8 line rests low at end", line_o, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule